// File: doc/BRIEF.md
# Write-Once System Configuration Register with Lock Window

This block holds one 8-bit configuration byte at a single bus address. Three of its bits (converter power-up, clock select, clock-monitor enable) can be rewritten at any time. Four others (interrupt edge select, oscillator start delay and the two rate-select bits) are protected. They accept one register write after reset, and that write must come within a fixed window of bus-clock cycles. After that write, or once the window closes, the protected bits hold their value until the next reset. A test-mode input lifts the protection, so every bit can be rewritten as often as needed.

Each configuration bit also drives its own output. When the converter power-up bit goes from 0 to 1, a counter starts. A converter-ready output goes high after a set number of cycles, which stands for the analog settling time. Reads return the register when the bus address matches, and 0 otherwise.

Top module: `syscfg_guard`

## Requirements
- R1: After reset the register reads 0x10: oscillator delay (bit 4) is 1 and every other bit is 0. The bit outputs match this value and converter-ready is low.
- R2: The free bits can be written by any write to the register address, at any time and any number of times. These are bit 7 (converter power-up), bit 6 (clock select) and bit 3 (clock-monitor enable).
- R3: The protected bits take their values from the first register write after reset. These are bit 5 (interrupt edge), bit 4 (oscillator delay) and bits 1:0 (rate select). Later writes leave them unchanged.
- R4: Counting the clock edges after reset release from 1, a write on edge 64 or earlier updates the protected bits. With no earlier write, a write on edge 65 or later leaves them unchanged.
- R5: Any write to the register address uses up the single protected write, including one whose protected-bit data equals the current value.
- R6: While testMode is high, every write updates all writable bits, any number of times. Writes made in test mode still use up the single write, and the window keeps running, so the lock applies once testMode drops.
- R7: Bit 2 always reads 0, and writes to it have no effect.
- R8: Converter-ready goes high SETTLE_CYCLES clock edges after the edge that writes the power-up bit from 0 to 1. Writing 1 while the bit is already 1 does not restart the count.
- R9: Writing the power-up bit to 0 drops converter-ready in the cycle after that write edge.
- R10: Reads at any other address return 0. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | High to lift the write-once protection |
| busAddr | input | ADDR_W | Bus address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe, one write per high cycle |
| busRdData | output | 8 | Read data, combinational from busAddr |
| cfgConvPwr | output | 1 | Converter power-up (bit 7) |
| cfgClkSel | output | 1 | Clock select (bit 6) |
| cfgIrqEdge | output | 1 | Interrupt edge select (bit 5) |
| cfgOscDelay | output | 1 | Oscillator start delay (bit 4) |
| cfgMonEn | output | 1 | Clock-monitor enable (bit 3) |
| cfgRate | output | 2 | Rate select (bits 1:0) |
| convReady | output | 1 | Converter settled |

## Verification
If the lock state is wrong, it shows up at the first write after the point where the lock should change. The protected bits either take a write they should refuse or refuse one they should take, and a read on the following cycle exposes it. This makes the writes on edges 64 and 65 after reset the sharp tests. A miscounted settle counter moves the rise of convReady away from exactly SETTLE_CYCLES edges after the power-up write. Missing clear logic leaves convReady high in the cycle after the power-up bit is cleared.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;
  typedef struct packed {
    logic wrFree;
    logic wrProt;
  } cfgStrobe_t;

  localparam logic [7:0] RESET_VAL = 8'h10;
  localparam logic [7:0] FREE_MASK = 8'hC8;
  localparam logic [7:0] PROT_MASK = 8'h33;
endpackage

// File: rtl/syscfg_ctrl.sv
module syscfg_ctrl
  import syscfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h40,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output cfgStrobe_t        strobe,
  output logic              rdHit,
  output logic              lockClosed
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] winCnt;
  logic          usedQ;
  logic          wrHit;
  logic          winDone;

  assign rdHit   = (busAddr == REG_ADDR);
  assign wrHit   = busWrEn && rdHit;
  assign winDone = (winCnt == CW'(WINDOW));
  assign lockClosed = usedQ || winDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      usedQ  <= 1'b0;
    end else begin
      if (!winDone) winCnt <= winCnt + CW'(1);
      if (wrHit) usedQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.wrFree = wrHit;
    strobe.wrProt = wrHit && (testMode || !lockClosed);
  end
endmodule

// File: rtl/syscfg_data.sv
module syscfg_data
  import syscfg_pkg::*;
#(
  parameter int SETTLE_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  input  logic [7:0] wrData,
  input  logic       rdHit,
  output logic [7:0] cfgQ,
  output logic [7:0] rdData,
  output logic       convReady
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  logic [7:0]    regQ;
  logic [7:0]    wrMask;
  logic [SW-1:0] settleCnt;
  logic          settled;

  always_comb begin
    wrMask = '0;
    if (strobe.wrFree) wrMask = wrMask | FREE_MASK;
    if (strobe.wrProt) wrMask = wrMask | PROT_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= RESET_VAL;
    else       regQ <= (regQ & ~wrMask) | (wrData & wrMask);
  end

  assign settled = (settleCnt == SW'(SETTLE_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             settleCnt <= '0;
    else if (!regQ[7])     settleCnt <= '0;
    else if (!settled)     settleCnt <= settleCnt + SW'(1);
  end

  assign convReady = regQ[7] && settled;
  assign cfgQ      = regQ;
  assign rdData    = rdHit ? regQ : 8'h00;
endmodule

// File: rtl/syscfg_guard.sv
module syscfg_guard
  import syscfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h40,
  parameter int WINDOW = 64,
  parameter int SETTLE_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWrEn,
  output logic [7:0]        busRdData,
  output logic              cfgConvPwr,
  output logic              cfgClkSel,
  output logic              cfgIrqEdge,
  output logic              cfgOscDelay,
  output logic              cfgMonEn,
  output logic [1:0]        cfgRate,
  output logic              convReady
);
  cfgStrobe_t ctrlStrobe;
  logic       rdHit;
  logic       lockClosed;
  logic [7:0] cfgQ;

  syscfg_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .busAddr(busAddr),
    .busWrEn(busWrEn), .strobe(ctrlStrobe), .rdHit(rdHit), .lockClosed(lockClosed)
  );

  syscfg_data #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_data (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .wrData(busWrData),
    .rdHit(rdHit), .cfgQ(cfgQ), .rdData(busRdData), .convReady(convReady)
  );

  assign cfgConvPwr  = cfgQ[7];
  assign cfgClkSel   = cfgQ[6];
  assign cfgIrqEdge  = cfgQ[5];
  assign cfgOscDelay = cfgQ[4];
  assign cfgMonEn    = cfgQ[3];
  assign cfgRate     = cfgQ[1:0];
endmodule

// File: rtl/syscfg_guard_checker.sv
module syscfg_guard_checker #(
  parameter int WINDOW = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       testMode,
  input logic       lockClosed,
  input logic [7:0] busRdData,
  input logic       cfgConvPwr,
  input logic       cfgIrqEdge,
  input logic       cfgOscDelay,
  input logic [1:0] cfgRate,
  input logic       convReady
);
  localparam int CW = $clog2(WINDOW + 1);
  logic [CW-1:0] edgeCnt;
  logic [3:0]    protBits;

  assign protBits = {cfgIrqEdge, cfgOscDelay, cfgRate};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (edgeCnt != CW'(WINDOW)) edgeCnt <= edgeCnt + CW'(1);
  end

  // R3 / R6: a closed lock outside test mode freezes the protected bits
  a_r3_prot_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (lockClosed && !testMode) |=> $stable(protBits));

  // R4: the lock stays closed once closed
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockClosed |=> lockClosed);

  // R4: the window ends after WINDOW edges
  a_r4_window_end: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == CW'(WINDOW)) |-> lockClosed);

  // R7: reserved bit reads zero
  a_r7_bit2_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[2] == 1'b0);

  // R8: ready only with power on
  a_r8_ready_needs_pwr: assert property (@(posedge clk) disable iff (!rstN)
    convReady |-> cfgConvPwr);

  // R8: ready never rises in the cycle power comes up
  a_r8_no_instant_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReady) |-> $past(cfgConvPwr));
endmodule

bind syscfg_guard syscfg_guard_checker #(.WINDOW(WINDOW)) u_checker (
  .clk(clk), .rstN(rstN), .testMode(testMode), .lockClosed(lockClosed),
  .busRdData(busRdData), .cfgConvPwr(cfgConvPwr), .cfgIrqEdge(cfgIrqEdge),
  .cfgOscDelay(cfgOscDelay), .cfgRate(cfgRate), .convReady(convReady)
);

// File: tb/syscfg_guard_bench.sv
module syscfg_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REG_A = 8'h40;
  localparam logic [7:0] OTHER_A = 8'h41;
  localparam int SETTLE = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       testMode = 1'b0;
  logic [7:0] busAddr = REG_A;
  logic [7:0] busWrData = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busRdData;
  logic       cfgConvPwr, cfgClkSel, cfgIrqEdge, cfgOscDelay, cfgMonEn, convReady;
  logic [1:0] cfgRate;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  syscfg_guard u_syscfg_guard (
    .clk(clk), .rstN(rstN), .testMode(testMode), .busAddr(busAddr),
    .busWrData(busWrData), .busWrEn(busWrEn), .busRdData(busRdData),
    .cfgConvPwr(cfgConvPwr), .cfgClkSel(cfgClkSel), .cfgIrqEdge(cfgIrqEdge),
    .cfgOscDelay(cfgOscDelay), .cfgMonEn(cfgMonEn), .cfgRate(cfgRate),
    .convReady(convReady)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic doReset(logic tm);
    @(negedge clk);
    rstN = 1'b0; testMode = tm; busWrEn = 1'b0; busAddr = REG_A;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // one write, consumes one edge, returns at the next negedge
  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = REG_A;
  endtask

  task automatic readCheck(string req, logic [7:0] a, logic [7:0] exp);
    busAddr = a;
    #1;
    check(req, busRdData, exp);
    busAddr = REG_A;
  endtask

  task automatic testResetState();
    doReset(1'b0);
    readCheck("R1 read", REG_A, 8'h10);
    check("R1 outs", {cfgConvPwr, cfgClkSel, cfgIrqEdge, cfgOscDelay, cfgMonEn, 1'b0, cfgRate}, 8'h10);
    check("R1 ready", {7'b0, convReady}, 8'h00);
  endtask

  task automatic testFirstWrite();
    doReset(1'b0);
    busWrite(REG_A, 8'h23);
    readCheck("R3 first write", REG_A, 8'h23);
    busWrite(REG_A, 8'hD8);
    readCheck("R3 second write ignored, R2 free taken", REG_A, 8'hEB);
    busWrite(REG_A, 8'h00);
    readCheck("R2 free cleared again", REG_A, 8'h23);
  endtask

  task automatic testWindowEdge();
    doReset(1'b0);
    repeat (63) @(posedge clk);
    @(negedge clk);
    busWrite(REG_A, 8'h33);
    readCheck("R4 write on edge 64", REG_A, 8'h33);
    doReset(1'b0);
    repeat (64) @(posedge clk);
    @(negedge clk);
    busWrite(REG_A, 8'hE3);
    readCheck("R4 write on edge 65", REG_A, 8'hD0);
  endtask

  task automatic testFreeOnlyUses();
    doReset(1'b0);
    busWrite(REG_A, 8'h18);
    readCheck("R5 free-only write", REG_A, 8'h18);
    busWrite(REG_A, 8'h03);
    readCheck("R5 shot used", REG_A, 8'h10);
  endtask

  task automatic testTestMode();
    doReset(1'b1);
    busWrite(REG_A, 8'h33);
    busWrite(REG_A, 8'h02);
    readCheck("R6 rewrite", REG_A, 8'h02);
    busWrite(REG_A, 8'hFF);
    readCheck("R7 bit2 reads 0", REG_A, 8'hFB);
    busWrite(REG_A, 8'h11);
    readCheck("R6 third write", REG_A, 8'h11);
    testMode = 1'b0;
    busWrite(REG_A, 8'h00);
    readCheck("R6 lock after exit", REG_A, 8'h11);
  endtask

  task automatic testOtherAddr();
    doReset(1'b0);
    busWrite(OTHER_A, 8'hFF);
    readCheck("R10 other write no effect", REG_A, 8'h10);
    readCheck("R10 other read zero", OTHER_A, 8'h00);
    busWrite(REG_A, 8'h01);
    readCheck("R10 shot still available", REG_A, 8'h01);
  endtask

  task automatic testSettle();
    doReset(1'b0);
    busWrite(REG_A, 8'h90);
    repeat (SETTLE - 2) @(posedge clk);
    @(negedge clk);
    busWrite(REG_A, 8'h90);
    check("R8 not ready early", {7'b0, convReady}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R8 ready on time", {7'b0, convReady}, 8'h01);
    busWrite(REG_A, 8'h10);
    check("R9 ready drops", {7'b0, convReady}, 8'h00);
    busWrite(REG_A, 8'h80);
    @(posedge clk); @(negedge clk);
    check("R9 restart not ready", {7'b0, convReady}, 8'h00);
  endtask

  initial begin
    testResetState();
    testFirstWrite();
    testWindowEdge();
    testFreeOnlyUses();
    testTestMode();
    testOtherAddr();
    testSettle();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule